// File: doc/BRIEF.md
# Dual-Lane Packed ALU with Trellis Decision History

This block is the packed-arithmetic slice of a 40-bit datapath ALU. In packed mode the low 32 bits of each operand are split into two independent signed 16-bit lanes. The slice offers lane add, lane subtract, lane maximum, lane minimum, and a lane arithmetic right shift by one or two bits. The 40-bit result carries the two lane results in its low 32 bits. The eight guard bits above them copy the sign of the upper lane, so the value stays a valid 40-bit signed quantity for whatever consumes it next.

The lane maximum and minimum exist to speed up the add-compare-select step of a trellis decoder. Each lane compares two path metrics. The same instruction also keeps, for every lane, one bit that says which metric won. These decision bits are written into a 32-bit history register at a write pointer. The pointer then moves on by the lane count and wraps at the register width, so successive decoding stages fill the register with no software bookkeeping.

The result is combinational from the operands, the opcode and the shift select. The history register and its pointer are the only state. They change on a clock edge, and only when an issued operation is a lane maximum or a lane minimum.

Top module: `simd_vit_alu`

## Requirements
- R1: While reset is asserted (rst_n low), the history register and the history pointer are cleared to zero, and any issued operation leaves them at zero.
- R2: Opcode 3'b000 adds the lanes: lane 0 in bits 15:0 and lane 1 in bits 31:16, each summed modulo 2^16 with no carry from lane 0 into lane 1.
- R3: Opcode 3'b001 subtracts per lane (a minus b), modulo 2^16, with no borrow between lanes.
- R4: Opcode 3'b010 returns the signed maximum of each lane. On a tie it returns the lane of operand a.
- R5: Opcode 3'b011 returns the signed minimum of each lane. On a tie it returns the lane of operand a.
- R6: Opcode 3'b100 shifts each lane of operand a arithmetically right by 1 when shamt is 0, or by 2 when shamt is 1. Operand b has no effect.
- R7: For every opcode, result bits 39:32 equal result bit 31. Operand bits 39:32 have no effect on any output.
- R8: On a clock edge with issue high and opcode 3'b010 or 3'b011, the decision of lane k is written into history bit (pointer + k) mod 32. The decision is 1 when operand b's lane was selected (strictly greater for maximum, strictly smaller for minimum) and 0 otherwise. All other history bits keep their value.
- R9: Each such edge advances the history pointer by 2, modulo 32. The pointer is therefore always even, and it returns to its start after 16 updates.
- R10: When issue is low, or the opcode is not 3'b010 or 3'b011, the history register and the pointer hold. Opcodes 3'b101 to 3'b111 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of history state |
| issue | input | 1 | Operation is issued this cycle (enables history update) |
| opcode | input | 3 | Packed operation select |
| opnd_a | input | 40 | First operand |
| opnd_b | input | 40 | Second operand |
| shamt | input | 1 | Shift amount select: 0 shifts by 1, 1 shifts by 2 |
| result | output | 40 | Packed result with sign-extended guard bits |
| hist | output | 32 | Decision history register |
| hist_ptr | output | 5 | Next history write position |

## Verification
An issued lane maximum or minimum does two things in the same cycle: it drives the selected metrics onto the result, and it commits two decision bits while the pointer moves. A wrong write position or a stale decision can therefore hide behind a correct result. The bench provokes this with long runs of issued compare operations that walk the pointer through the 30-to-0 wrap. It also uses ties and operands near the signed extremes, which flip decisions at the edge of the comparison, and it mixes in non-issued compares and other opcodes that must leave the state alone. Each operation is judged twice: the result is checked in mid-cycle against a bench model, and the history and pointer are checked after the edge against a model register that is updated only for issued compares.

// File: rtl/simd_vit_pkg.sv
package simd_vit_pkg;

  typedef enum logic [2:0] {
    OP_PADD = 3'd0,
    OP_PSUB = 3'd1,
    OP_PMAX = 3'd2,
    OP_PMIN = 3'd3,
    OP_PSRA = 3'd4
  } simd_op_e;

  // True for the opcodes that log decisions into the history register
  function automatic logic is_cmp_op(input logic [2:0] op);
    return (op == OP_PMAX) || (op == OP_PMIN);
  endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_vit_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic [2:0]        op,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              shamt,
  output logic [LANE_W-1:0] res,
  output logic              dec
);

  // Arithmetic helpers, kept as functions so the intent is readable
  function automatic logic [LANE_W-1:0] wrap_add(input logic [LANE_W-1:0] x,
                                                 input logic [LANE_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [LANE_W-1:0] wrap_sub(input logic [LANE_W-1:0] x,
                                                 input logic [LANE_W-1:0] y);
    return x - y;
  endfunction

  function automatic logic [LANE_W-1:0] sra_lane(input logic [LANE_W-1:0] x,
                                                 input logic by_two);
    logic signed [LANE_W-1:0] sx;
    sx = x;
    return by_two ? LANE_W'(sx >>> 2) : LANE_W'(sx >>> 1);
  endfunction

  logic b_gt_a;
  logic b_lt_a;

  assign b_gt_a = $signed(b) > $signed(a);
  assign b_lt_a = $signed(b) < $signed(a);

  always_comb begin
    res = '0;
    dec = 1'b0;
    case (op)
      OP_PADD: res = wrap_add(a, b);
      OP_PSUB: res = wrap_sub(a, b);
      OP_PMAX: begin
        dec = b_gt_a;
        res = b_gt_a ? b : a;
      end
      OP_PMIN: begin
        dec = b_lt_a;
        res = b_lt_a ? b : a;
      end
      OP_PSRA: res = sra_lane(a, shamt);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/simd_vit_hist.sv
module simd_vit_hist #(
  parameter int HIST_W = 32,
  parameter int LANES  = 2,
  localparam int PTR_W = $clog2(HIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  dec,
  output logic [HIST_W-1:0] hist_q,
  output logic [PTR_W-1:0]  ptr_q
);

  logic [HIST_W-1:0] hist_d;
  logic [PTR_W-1:0]  ptr_d;

  always_comb begin
    hist_d = hist_q;
    ptr_d  = ptr_q;
    if (wr_en) begin
      for (int k = 0; k < LANES; k++) begin
        hist_d[PTR_W'(ptr_q + PTR_W'(k))] = dec[k];
      end
      ptr_d = PTR_W'(ptr_q + PTR_W'(LANES));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      ptr_q  <= '0;
    end else begin
      hist_q <= hist_d;
      ptr_q  <= ptr_d;
    end
  end

endmodule

// File: rtl/simd_vit_alu.sv
module simd_vit_alu
  import simd_vit_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int HIST_W = 32,
  localparam int PTR_W = $clog2(HIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              shamt,
  output logic [DATA_W-1:0] result,
  output logic [HIST_W-1:0] hist,
  output logic [PTR_W-1:0]  hist_ptr
);

  localparam int PACK_W  = LANES * LANE_W;
  localparam int GUARD_W = DATA_W - PACK_W;

  // Named internal events for the checker
  logic [PACK_W-1:0] packed_res;
  logic [LANES-1:0]  lane_dec;
  logic              cmp_fire;

  // Guard bits of the operands take no part in packed operations
  logic guard_in_unused;
  assign guard_in_unused = ^{opnd_a[DATA_W-1:PACK_W], opnd_b[DATA_W-1:PACK_W]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane #(
      .LANE_W(LANE_W)
    ) u_lane (
      .op   (opcode),
      .a    (opnd_a[g*LANE_W +: LANE_W]),
      .b    (opnd_b[g*LANE_W +: LANE_W]),
      .shamt(shamt),
      .res  (packed_res[g*LANE_W +: LANE_W]),
      .dec  (lane_dec[g])
    );
  end

  assign result   = {{GUARD_W{packed_res[PACK_W-1]}}, packed_res};
  assign cmp_fire = issue & is_cmp_op(opcode);

  simd_vit_hist #(
    .HIST_W(HIST_W),
    .LANES (LANES)
  ) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cmp_fire),
    .dec   (lane_dec),
    .hist_q(hist),
    .ptr_q (hist_ptr)
  );

endmodule

// File: rtl/simd_vit_alu_chk.sv
module simd_vit_alu_chk
  import simd_vit_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int HIST_W = 32,
  localparam int PTR_W = $clog2(HIST_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        opcode,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result,
  input logic [HIST_W-1:0] hist,
  input logic [PTR_W-1:0]  hist_ptr,
  input logic              cmp_fire,
  input logic [LANES-1:0]  lane_dec
);

  localparam int PACK_W = LANES * LANE_W;

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> hist_ptr == PTR_W'($past(hist_ptr) + PTR_W'(LANES))); // R9

  AST_PTR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ptr[0] == 1'b0); // R9

  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_fire |=> $stable(hist) && $stable(hist_ptr)); // R10

  AST_HIST_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> hist[$past(hist_ptr)] == $past(lane_dec[0])); // R8

  AST_HIST_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> hist[PTR_W'($past(hist_ptr) + 1'b1)] == $past(lane_dec[1])); // R8

  AST_HIST_TWO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> $countones(hist ^ $past(hist)) <= LANES); // R8

  AST_GUARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    result[DATA_W-1:PACK_W] == {(DATA_W-PACK_W){result[PACK_W-1]}}); // R7

  for (genvar g = 0; g < LANES; g++) begin : g_bound
    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_PMAX |->
        ($signed(result[g*LANE_W +: LANE_W]) >= $signed(opnd_a[g*LANE_W +: LANE_W])) &&
        ($signed(result[g*LANE_W +: LANE_W]) >= $signed(opnd_b[g*LANE_W +: LANE_W]))); // R4

    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == OP_PMIN |->
        ($signed(result[g*LANE_W +: LANE_W]) <= $signed(opnd_a[g*LANE_W +: LANE_W])) &&
        ($signed(result[g*LANE_W +: LANE_W]) <= $signed(opnd_b[g*LANE_W +: LANE_W]))); // R5
  end

endmodule

bind simd_vit_alu simd_vit_alu_chk #(
  .DATA_W(DATA_W),
  .LANE_W(LANE_W),
  .LANES (LANES),
  .HIST_W(HIST_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .opcode  (opcode),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .result  (result),
  .hist    (hist),
  .hist_ptr(hist_ptr),
  .cmp_fire(cmp_fire),
  .lane_dec(lane_dec)
);

// File: tb/simd_vit_alu_tb.sv
module simd_vit_alu_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [2:0]  opcode;
  logic [39:0] opnd_a;
  logic [39:0] opnd_b;
  logic        shamt;
  logic [39:0] result;
  logic [31:0] hist;
  logic [4:0]  hist_ptr;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_hist;
  logic [4:0]  m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_vit_alu u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .opcode  (opcode),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .shamt   (shamt),
    .result  (result),
    .hist    (hist),
    .hist_ptr(hist_ptr)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Bench view of the lanes: integer arithmetic, truncated afterwards
  function automatic logic [39:0] model_res(input logic [2:0] op, input logic [39:0] a,
                                            input logic [39:0] b, input logic sh);
    logic [31:0] p;
    int x, y, r;
    p = '0;
    for (int k = 0; k < 2; k++) begin
      x = $signed(a[16*k +: 16]);
      y = $signed(b[16*k +: 16]);
      case (op)
        3'd0: r = x + y;
        3'd1: r = x - y;
        3'd2: r = (y > x) ? y : x;
        3'd3: r = (y < x) ? y : x;
        3'd4: r = sh ? (x >>> 2) : (x >>> 1);
        default: r = 0;
      endcase
      p[16*k +: 16] = r[15:0];
    end
    return {{8{p[31]}}, p};
  endfunction

  function automatic logic model_dec(input logic [2:0] op, input logic [39:0] a,
                                     input logic [39:0] b, input int k);
    int x, y;
    x = $signed(a[16*k +: 16]);
    y = $signed(b[16*k +: 16]);
    if (op == 3'd2) return y > x;
    if (op == 3'd3) return y < x;
    return 1'b0;
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  // Drive at negedge, judge result mid-cycle, judge state after the edge
  task automatic do_op(input logic [2:0] op, input logic [39:0] a, input logic [39:0] b,
                       input logic sh, input logic iss);
    logic cmp;
    @(negedge clk);
    issue  = iss;
    opcode = op;
    opnd_a = a;
    opnd_b = b;
    shamt  = sh;
    #1;
    check(req_of(op), 64'(result), 64'(model_res(op, a, b, sh)));
    check("R7", 64'(result[39:32]), 64'({8{result[31]}}));
    cmp = iss && (op == 3'd2 || op == 3'd3);
    if (cmp) begin
      m_hist[m_ptr]        = model_dec(op, a, b, 0);
      m_hist[m_ptr + 5'd1] = model_dec(op, a, b, 1);
      m_ptr                = m_ptr + 5'd2;
    end
    @(posedge clk);
    #1;
    check(cmp ? "R8" : "R10", 64'(hist), 64'(m_hist));
    check(cmp ? "R9" : "R10", 64'(hist_ptr), 64'(m_ptr));
  endtask

  function automatic logic [15:0] pick_lane();
    case ($urandom_range(0, 5))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    logic [4:0] start_ptr;
    void'($urandom(32'd20240611));
    rst_n  = 1'b0;
    issue  = 1'b1;
    opcode = 3'd2;
    opnd_a = 40'h00_0000_0000;
    opnd_b = 40'h00_7FFF_7FFF;
    shamt  = 1'b0;
    m_hist = '0;
    m_ptr  = '0;
    repeat (4) @(posedge clk);
    #1;
    check("R1", 64'(hist), 64'd0);
    check("R1", 64'(hist_ptr), 64'd0);
    @(negedge clk);
    issue = 1'b0;
    rst_n = 1'b1;
    #1;
    check("R1", 64'(hist), 64'd0);
    check("R1", 64'(hist_ptr), 64'd0);

    // R2: no carry from lane 0 into lane 1; signed overflow wraps
    do_op(3'd0, 40'h00_0001_FFFF, 40'h00_0000_0001, 1'b0, 1'b1);
    do_op(3'd0, 40'h00_7FFF_0000, 40'h00_0001_0000, 1'b0, 1'b0);
    // R3: no borrow between lanes
    do_op(3'd1, 40'h00_0005_0000, 40'h00_0000_0001, 1'b0, 1'b1);
    // R4/R5 ties keep operand a, decision 0 (R8)
    do_op(3'd2, 40'h00_1234_8000, 40'h00_1234_8000, 1'b0, 1'b1);
    do_op(3'd3, 40'h00_0001_0001, 40'h00_FFFF_0001, 1'b0, 1'b1);
    do_op(3'd2, 40'h00_8000_7FFE, 40'h00_7FFF_7FFF, 1'b0, 1'b1);
    // R6: sign is kept; operand b has no effect
    do_op(3'd4, 40'h00_8000_0003, 40'h00_FFFF_FFFF, 1'b1, 1'b1);
    do_op(3'd4, 40'h00_8000_0003, 40'h00_1234_5678, 1'b0, 1'b1);
    // R7: operand guard bits have no effect
    do_op(3'd0, 40'hAA_0001_0002, 40'h55_0003_0004, 1'b0, 1'b1);
    do_op(3'd2, 40'hFF_0001_0002, 40'h00_0003_0000, 1'b0, 1'b1);
    // R10: non-issued compare and unused opcodes leave state alone
    do_op(3'd2, 40'h00_0000_0000, 40'h00_7FFF_7FFF, 1'b0, 1'b0);
    do_op(3'd5, 40'h00_1111_2222, 40'h00_3333_4444, 1'b0, 1'b1);
    do_op(3'd7, 40'h00_FFFF_FFFF, 40'h00_FFFF_FFFF, 1'b1, 1'b1);

    // R9: sixteen issued compares bring the pointer back through the wrap
    start_ptr = hist_ptr;
    for (int i = 0; i < 16; i++) begin
      do_op((i % 2 == 0) ? 3'd2 : 3'd3, {8'h00, pick_lane(), pick_lane()},
            {8'h00, pick_lane(), pick_lane()}, 1'b0, 1'b1);
    end
    check("R9", 64'(hist_ptr), 64'(start_ptr));

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a0, a1, b0, b1;
      a0 = pick_lane();
      a1 = pick_lane();
      b0 = ($urandom_range(0, 5) == 0) ? a0 : pick_lane();
      b1 = ($urandom_range(0, 5) == 0) ? a1 : pick_lane();
      do_op(3'($urandom_range(0, 7)), {8'($urandom), a1, a0}, {8'($urandom), b1, b0},
            1'($urandom), ($urandom_range(0, 3) != 0));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule